// File: doc/BRIEF.md
# Retire Trace Lockstep Comparator

This block checks a processor core against a trusted model, one instruction at a time. It takes two streams of per-instruction retirement records. One comes from the reference model and one from the core under test. Each record holds:

- the retirement order number
- the instruction word
- the program counter before and after the instruction
- the destination register address and its write data
- a trap flag
- the memory access address, the read and write byte masks, and the read and write data

The two records that carry the same retirement position are compared field group by field group. The first pair that disagrees is held, and the block reports the order number and the kind of field that diverged. This points at the exact instruction that went wrong rather than at some later symptom.

Each input channel is a valid/ready handshake and feeds its own small queue. Either source may therefore run several records ahead of the other. The channel that is ahead is held off only when its queue is full. After a divergence the block stops taking records on both channels. It holds its report until the synchronous clear input is pulsed. The clear empties both queues and returns the block to its reset state. A running count gives the number of record pairs that matched.

Top module: `lockstep_compare`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, `mismatch` is 0, `fail_code` is 0, `match_count` is 0, both queues are empty, and `ref_ready` and `dut_ready` are 1.
- R2: Records are paired by position in each stream, whatever cycle they arrive in. Each agreeing pair adds exactly 1 to `match_count`, one cycle after both records are queued.
- R3: Each channel queues up to `FIFO_DEPTH` (default 4) records. Its ready output is 0 while its queue holds `FIFO_DEPTH` records, and the other channel stays ready.
- R4: A difference in either program counter field reports `fail_code` 1, with `fail_order` set to the reference record's order number.
- R5: A difference in the instruction word reports `fail_code` 2.
- R6: A difference in destination register address, or in write data when that address is non-zero, reports `fail_code` 3. Write data is ignored when both addresses are 0.
- R7: A difference in memory address, read mask, write mask, or data reports `fail_code` 4. Mask bit i enables data bits 8i+7..8i, and data is compared only on the byte lanes that the matching mask enables.
- R8: A difference in the trap flag reports `fail_code` 5.
- R9: When several field groups differ in one pair, the lowest code among 1 to 5 is reported.
- R10: When the two paired records carry different order numbers, `fail_code` is 6 whatever the other fields hold.
- R11: Once `mismatch` is 1, both readies are 0, and `match_count`, `fail_order` and `fail_code` hold their values until `clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the report, the count and both queues |
| ref_valid | input | 1 | Reference record valid |
| ref_ready | output | 1 | Reference record accepted when high with valid |
| ref_order | input | 16 | Reference retirement order number |
| ref_insn | input | 32 | Reference instruction word |
| ref_pc_before | input | 32 | Reference PC of the instruction |
| ref_pc_after | input | 32 | Reference PC of the next instruction |
| ref_rd_addr | input | 5 | Reference destination register |
| ref_rd_data | input | 32 | Reference register write data |
| ref_trap | input | 1 | Reference trap flag |
| ref_mem_addr | input | 32 | Reference memory address |
| ref_mem_rmask | input | 4 | Reference read byte mask |
| ref_mem_wmask | input | 4 | Reference write byte mask |
| ref_mem_rdata | input | 32 | Reference memory read data |
| ref_mem_wdata | input | 32 | Reference memory write data |
| dut_valid | input | 1 | Core record valid |
| dut_ready | output | 1 | Core record accepted when high with valid |
| dut_order | input | 16 | Core retirement order number |
| dut_insn | input | 32 | Core instruction word |
| dut_pc_before | input | 32 | Core PC of the instruction |
| dut_pc_after | input | 32 | Core PC of the next instruction |
| dut_rd_addr | input | 5 | Core destination register |
| dut_rd_data | input | 32 | Core register write data |
| dut_trap | input | 1 | Core trap flag |
| dut_mem_addr | input | 32 | Core memory address |
| dut_mem_rmask | input | 4 | Core read byte mask |
| dut_mem_wmask | input | 4 | Core write byte mask |
| dut_mem_rdata | input | 32 | Core memory read data |
| dut_mem_wdata | input | 32 | Core memory write data |
| mismatch | output | 1 | Sticky divergence flag |
| fail_order | output | 16 | Order number of the first divergent pair |
| fail_code | output | 3 | Diverged field group (0 none, 1 PC, 2 instruction, 3 register write, 4 memory, 5 trap, 6 order) |
| match_count | output | 32 | Number of agreeing pairs |

## Verification
The assertions check the behaviours that must hold every cycle:

- no queue is written when full or read when empty
- the divergence flag stays set, and the count and report stay frozen, until a clear
- both readies are low while a divergence is held
- the count never steps by more than one
- a clear always returns the block to an empty report

Only the bench's scenarios show the rest:

- which code each kind of field difference produces
- the priority among several differing groups
- that an unenabled byte lane or a write to register 0 is ignored
- that pairing survives one stream running a full queue ahead of the other

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    parameter int XLEN   = 32;
    parameter int ORD_W  = 16;
    parameter int RA_W   = 5;
    parameter int MASK_W = XLEN / 8;

    typedef enum logic [2:0] {
        DIFF_NONE  = 3'd0,
        DIFF_PC    = 3'd1,
        DIFF_INSN  = 3'd2,
        DIFF_RDW   = 3'd3,
        DIFF_MEM   = 3'd4,
        DIFF_TRAP  = 3'd5,
        DIFF_ORDER = 3'd6
    } diff_code_e;

    typedef struct packed {
        logic [ORD_W-1:0]  order;
        logic [XLEN-1:0]   insn;
        logic [XLEN-1:0]   pc_before;
        logic [XLEN-1:0]   pc_after;
        logic [RA_W-1:0]   rd_addr;
        logic [XLEN-1:0]   rd_data;
        logic              trap;
        logic [XLEN-1:0]   mem_addr;
        logic [MASK_W-1:0] mem_rmask;
        logic [MASK_W-1:0] mem_wmask;
        logic [XLEN-1:0]   mem_rdata;
        logic [XLEN-1:0]   mem_wdata;
    } retire_rec_t;

    // Expand a byte-lane mask to a bit mask over the data word.
    function automatic logic [XLEN-1:0] lane_bits(input logic [MASK_W-1:0] m);
        logic [XLEN-1:0] b;
        for (int i = 0; i < MASK_W; i++) begin
            b[i*8 +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

    // Classify a record pair; the order check dominates, then lowest group code.
    function automatic diff_code_e classify(input retire_rec_t a, input retire_rec_t b);
        logic rdw_bad;
        logic mem_bad;
        rdw_bad = (a.rd_addr != b.rd_addr) ||
                  ((a.rd_addr != '0) && (a.rd_data != b.rd_data));
        mem_bad = (a.mem_addr != b.mem_addr) ||
                  (a.mem_rmask != b.mem_rmask) ||
                  (a.mem_wmask != b.mem_wmask) ||
                  (((a.mem_rdata ^ b.mem_rdata) & lane_bits(a.mem_rmask)) != '0) ||
                  (((a.mem_wdata ^ b.mem_wdata) & lane_bits(a.mem_wmask)) != '0);
        if (a.order != b.order)                                           return DIFF_ORDER;
        if ((a.pc_before != b.pc_before) || (a.pc_after != b.pc_after))   return DIFF_PC;
        if (a.insn != b.insn)                                             return DIFF_INSN;
        if (rdw_bad)                                                      return DIFF_RDW;
        if (mem_bad)                                                      return DIFF_MEM;
        if (a.trap != b.trap)                                             return DIFF_TRAP;
        return DIFF_NONE;
    endfunction

endpackage

// File: rtl/retire_fifo.sv
module retire_fifo #(
    parameter type T     = logic,
    parameter int  DEPTH = 4
) (
    input  logic clk,
    input  logic flush,
    input  logic push,
    input  logic pop,
    input  T     din,
    output T     dout,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    T               store [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [CW-1:0]  fill;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    assign dout  = store[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (flush) push |-> !full); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (flush) pop |-> !empty); // R2

endmodule

// File: rtl/lockstep_judge.sv
module lockstep_judge
    import lockstep_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  retire_rec_t      ref_head,
    input  retire_rec_t      dut_head,
    input  logic             ref_empty,
    input  logic             dut_empty,
    output logic             pop,
    output logic             mismatch,
    output logic [ORD_W-1:0] fail_order,
    output diff_code_e       fail_code,
    output logic [CNT_W-1:0] match_count
);
    diff_code_e verdict;

    assign pop     = !ref_empty && !dut_empty && !mismatch;
    assign verdict = classify(ref_head, dut_head);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mismatch    <= 1'b0;
            fail_order  <= '0;
            fail_code   <= DIFF_NONE;
            match_count <= '0;
        end else if (pop) begin
            if (verdict != DIFF_NONE) begin
                mismatch   <= 1'b1;
                fail_order <= ref_head.order;
                fail_code  <= verdict;
            end else begin
                match_count <= match_count + CNT_W'(1);
            end
        end
    end

    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst || clear)
        mismatch |=> mismatch); // R11
    AST_FROZEN_REPORT: assert property (@(posedge clk) disable iff (rst || clear)
        mismatch |=> ($stable(match_count) && $stable(fail_order) && $stable(fail_code))); // R11
    AST_CODE_PRESENT: assert property (@(posedge clk) disable iff (rst || clear)
        $rose(mismatch) |-> (fail_code != DIFF_NONE)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst || clear)
        !mismatch |=> ((match_count == $past(match_count)) ||
                       (match_count == $past(match_count) + CNT_W'(1)))); // R2
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!mismatch && (match_count == '0) && (fail_code == DIFF_NONE))); // R1

endmodule

// File: rtl/lockstep_compare.sv
module lockstep_compare
    import lockstep_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              ref_valid,
    output logic              ref_ready,
    input  logic [ORD_W-1:0]  ref_order,
    input  logic [XLEN-1:0]   ref_insn,
    input  logic [XLEN-1:0]   ref_pc_before,
    input  logic [XLEN-1:0]   ref_pc_after,
    input  logic [RA_W-1:0]   ref_rd_addr,
    input  logic [XLEN-1:0]   ref_rd_data,
    input  logic              ref_trap,
    input  logic [XLEN-1:0]   ref_mem_addr,
    input  logic [MASK_W-1:0] ref_mem_rmask,
    input  logic [MASK_W-1:0] ref_mem_wmask,
    input  logic [XLEN-1:0]   ref_mem_rdata,
    input  logic [XLEN-1:0]   ref_mem_wdata,
    input  logic              dut_valid,
    output logic              dut_ready,
    input  logic [ORD_W-1:0]  dut_order,
    input  logic [XLEN-1:0]   dut_insn,
    input  logic [XLEN-1:0]   dut_pc_before,
    input  logic [XLEN-1:0]   dut_pc_after,
    input  logic [RA_W-1:0]   dut_rd_addr,
    input  logic [XLEN-1:0]   dut_rd_data,
    input  logic              dut_trap,
    input  logic [XLEN-1:0]   dut_mem_addr,
    input  logic [MASK_W-1:0] dut_mem_rmask,
    input  logic [MASK_W-1:0] dut_mem_wmask,
    input  logic [XLEN-1:0]   dut_mem_rdata,
    input  logic [XLEN-1:0]   dut_mem_wdata,
    output logic              mismatch,
    output logic [ORD_W-1:0]  fail_order,
    output logic [2:0]        fail_code,
    output logic [CNT_W-1:0]  match_count
);
    localparam int NCH = 2;   // channel 0 = reference, channel 1 = core

    retire_rec_t       in_rec [NCH];
    retire_rec_t       head   [NCH];
    logic [NCH-1:0]    ch_valid;
    logic [NCH-1:0]    ch_ready;
    logic [NCH-1:0]    ch_empty;
    logic [NCH-1:0]    ch_full;
    logic              pop;
    diff_code_e        code_q;

    assign in_rec[0] = '{order: ref_order, insn: ref_insn, pc_before: ref_pc_before,
                         pc_after: ref_pc_after, rd_addr: ref_rd_addr, rd_data: ref_rd_data,
                         trap: ref_trap, mem_addr: ref_mem_addr, mem_rmask: ref_mem_rmask,
                         mem_wmask: ref_mem_wmask, mem_rdata: ref_mem_rdata,
                         mem_wdata: ref_mem_wdata};
    assign in_rec[1] = '{order: dut_order, insn: dut_insn, pc_before: dut_pc_before,
                         pc_after: dut_pc_after, rd_addr: dut_rd_addr, rd_data: dut_rd_data,
                         trap: dut_trap, mem_addr: dut_mem_addr, mem_rmask: dut_mem_rmask,
                         mem_wmask: dut_mem_wmask, mem_rdata: dut_mem_rdata,
                         mem_wdata: dut_mem_wdata};
    assign ch_valid  = {dut_valid, ref_valid};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign ch_ready[c] = !ch_full[c] && !mismatch;
        retire_fifo #(.T(retire_rec_t), .DEPTH(FIFO_DEPTH)) u_queue (
            .clk   (clk),
            .flush (rst || clear),
            .push  (ch_valid[c] && ch_ready[c]),
            .pop   (pop),
            .din   (in_rec[c]),
            .dout  (head[c]),
            .empty (ch_empty[c]),
            .full  (ch_full[c])
        );
    end

    lockstep_judge #(.CNT_W(CNT_W)) u_judge (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .ref_head    (head[0]),
        .dut_head    (head[1]),
        .ref_empty   (ch_empty[0]),
        .dut_empty   (ch_empty[1]),
        .pop         (pop),
        .mismatch    (mismatch),
        .fail_order  (fail_order),
        .fail_code   (code_q),
        .match_count (match_count)
    );

    assign fail_code = code_q;
    assign ref_ready = ch_ready[0];
    assign dut_ready = ch_ready[1];

    AST_HALT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> (!ref_ready && !dut_ready)); // R11

endmodule

// File: tb/lockstep_compare_tb_top.sv
`timescale 1ns/1ps
module lockstep_compare_tb_top;
    import lockstep_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic ref_valid = 1'b0;
    logic dut_valid = 1'b0;
    retire_rec_t ref_r = '0;
    retire_rec_t dut_r = '0;
    logic ref_ready, dut_ready, mismatch;
    logic [ORD_W-1:0] fail_order;
    logic [2:0] fail_code;
    logic [31:0] match_count;

    always #2 clk = ~clk;   // 250 MHz

    lockstep_compare dut_i (
        .clk(clk), .rst(rst), .clear(clear),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_order(ref_r.order),
        .ref_insn(ref_r.insn), .ref_pc_before(ref_r.pc_before), .ref_pc_after(ref_r.pc_after),
        .ref_rd_addr(ref_r.rd_addr), .ref_rd_data(ref_r.rd_data), .ref_trap(ref_r.trap),
        .ref_mem_addr(ref_r.mem_addr), .ref_mem_rmask(ref_r.mem_rmask),
        .ref_mem_wmask(ref_r.mem_wmask), .ref_mem_rdata(ref_r.mem_rdata),
        .ref_mem_wdata(ref_r.mem_wdata),
        .dut_valid(dut_valid), .dut_ready(dut_ready), .dut_order(dut_r.order),
        .dut_insn(dut_r.insn), .dut_pc_before(dut_r.pc_before), .dut_pc_after(dut_r.pc_after),
        .dut_rd_addr(dut_r.rd_addr), .dut_rd_data(dut_r.rd_data), .dut_trap(dut_r.trap),
        .dut_mem_addr(dut_r.mem_addr), .dut_mem_rmask(dut_r.mem_rmask),
        .dut_mem_wmask(dut_r.mem_wmask), .dut_mem_rdata(dut_r.mem_rdata),
        .dut_mem_wdata(dut_r.mem_wdata),
        .mismatch(mismatch), .fail_order(fail_order), .fail_code(fail_code),
        .match_count(match_count)
    );

    typedef struct {
        int unsigned code;
        int unsigned order;
        string       req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic retire_rec_t mk(input int unsigned n);
        retire_rec_t r;
        r = '0;
        r.order     = ORD_W'(n);
        r.insn      = 32'h0000_0013 ^ (n << 7);
        r.pc_before = 32'h8000_0000 + n * 4;
        r.pc_after  = 32'h8000_0004 + n * 4;
        r.rd_addr   = RA_W'((n % 31) + 1);
        r.rd_data   = 32'h1000_0000 + n * 3;
        r.mem_addr  = 32'h2000_0000 + n * 8;
        return r;
    endfunction

    task automatic expect_item(input int unsigned code, input int unsigned order, input string req);
        exp_item_t e;
        e.code = code; e.order = order; e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: called at a negedge, returns at a negedge after acceptance.
    task automatic push_ref(input retire_rec_t r);
        ref_r = r; ref_valid = 1'b1;
        while (!ref_ready) @(negedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic push_dut(input retire_rec_t r);
        dut_r = r; dut_valid = 1'b1;
        while (!dut_ready) @(negedge clk);
        @(negedge clk);
        dut_valid = 1'b0;
    endtask

    task automatic push_pair(input retire_rec_t a, input retire_rec_t b,
                             input int unsigned code, input string req);
        expect_item(code, a.order, req);
        ref_r = a; dut_r = b; ref_valid = 1'b1; dut_valid = 1'b1;
        while (!(ref_ready && dut_ready)) @(negedge clk);
        @(negedge clk);
        ref_valid = 1'b0; dut_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic fail_case(input retire_rec_t a, input retire_rec_t b,
                             input int unsigned code, input string req);
        push_pair(a, b, code, req);
        repeat (3) @(negedge clk);
        check(mismatch == 1'b1, req, mismatch, 1);
        pulse_clear();
    endtask

    // Monitor: pops the expected queue on each count step or divergence.
    logic [31:0] prev_cnt = '0;
    logic prev_mis = 1'b0;
    always @(negedge clk) begin
        if (!rst && !clear) begin
            if (match_count == prev_cnt + 32'd1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected match", match_count, prev_cnt);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    check(e.code == 0, e.req, 0, e.code);
                end
            end
            if (mismatch && !prev_mis) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected mismatch", fail_code, 0);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    check(fail_code == 3'(e.code), e.req, fail_code, e.code);
                    check(fail_order == ORD_W'(e.order), {e.req, " order"}, fail_order, e.order);
                end
            end
        end
        prev_cnt = match_count;
        prev_mis = mismatch;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        retire_rec_t a, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mismatch == 0, "R1 mismatch", mismatch, 0);
        check(fail_code == 0, "R1 fail_code", fail_code, 0);
        check(match_count == 0, "R1 match_count", match_count, 0);
        check(ref_ready && dut_ready, "R1 readies", {ref_ready, dut_ready}, 3);

        // R2: lockstep pairs
        for (int i = 0; i < 3; i++) push_pair(mk(i), mk(i), 0, "R2 pair");
        repeat (2) @(negedge clk);
        check(match_count == 3, "R2 count", match_count, 3);

        // R3: reference runs a full queue ahead
        for (int i = 3; i < 7; i++) begin
            expect_item(0, i, "R3 skew pair");
            push_ref(mk(i));
        end
        check(ref_ready == 0, "R3 ref_ready full", ref_ready, 0);
        check(dut_ready == 1, "R3 dut_ready", dut_ready, 1);
        for (int i = 3; i < 7; i++) push_dut(mk(i));
        repeat (2) @(negedge clk);
        check(match_count == 7, "R2 count after skew", match_count, 7);
        check(ref_ready == 1, "R3 ref_ready drained", ref_ready, 1);
        // core runs ahead
        for (int i = 7; i < 9; i++) begin
            expect_item(0, i, "R2 core-ahead pair");
            push_dut(mk(i));
        end
        for (int i = 7; i < 9; i++) push_ref(mk(i));
        repeat (2) @(negedge clk);
        check(match_count == 9, "R2 count core ahead", match_count, 9);

        // R6 ignore: x0 write data differs
        a = mk(9); b = mk(9); a.rd_addr = '0; b.rd_addr = '0; b.rd_data = 32'hDEAD_BEEF;
        push_pair(a, b, 0, "R6 x0 ignored");
        // R7 ignore: unenabled byte lane differs
        a = mk(10); a.mem_rmask = 4'b0011; a.mem_rdata = 32'h1122_3344;
        b = a; b.mem_rdata = 32'hFF22_3344;
        push_pair(a, b, 0, "R7 lane ignored");
        repeat (2) @(negedge clk);
        check(match_count == 11, "R6 R7 count", match_count, 11);

        // R4 PC mismatch, then R11 freeze
        a = mk(11); b = a; b.pc_after = b.pc_after + 32'd4;
        push_pair(a, b, 1, "R4 pc");
        repeat (3) @(negedge clk);
        check(!ref_ready && !dut_ready, "R11 readies low", {ref_ready, dut_ready}, 0);
        check(match_count == 11, "R11 count frozen", match_count, 11);
        ref_valid = 1'b1; ref_r = mk(12);
        repeat (3) @(negedge clk);
        ref_valid = 1'b0;
        check(fail_order == 11, "R11 order held", fail_order, 11);
        check(fail_code == 1, "R11 code held", fail_code, 1);
        pulse_clear();
        check(mismatch == 0 && match_count == 0 && fail_code == 0, "R1 after clear",
              {mismatch, fail_code}, 0);
        check(ref_ready && dut_ready, "R1 readies after clear", {ref_ready, dut_ready}, 3);

        a = mk(20); b = a; b.insn = b.insn ^ 32'h0000_1000;
        fail_case(a, b, 2, "R5 insn");
        a = mk(21); b = a; b.rd_data = b.rd_data + 1;
        fail_case(a, b, 3, "R6 rd data");
        a = mk(22); b = a; b.rd_addr = b.rd_addr ^ 5'h1;
        fail_case(a, b, 3, "R6 rd addr");
        a = mk(23); a.mem_wmask = 4'b1000; a.mem_wdata = 32'hAB00_0000; b = a;
        b.mem_wdata = 32'hAC00_0000;
        fail_case(a, b, 4, "R7 wdata lane");
        a = mk(24); b = a; b.mem_addr = b.mem_addr + 4;
        fail_case(a, b, 4, "R7 mem addr");
        a = mk(25); b = a; b.trap = 1'b1;
        fail_case(a, b, 5, "R8 trap");
        a = mk(26); b = a; b.trap = 1'b1; b.pc_before = b.pc_before + 2;
        fail_case(a, b, 1, "R9 pc over trap");
        a = mk(27); b = a; b.insn = ~b.insn; b.mem_rmask = 4'b1111;
        fail_case(a, b, 2, "R9 insn over mem");
        a = mk(28); b = mk(29);
        fail_case(a, b, 6, "R10 order");
        // a good pair still counts after all the clears
        push_pair(mk(30), mk(30), 0, "R1 fresh pair");
        repeat (2) @(negedge clk);
        check(match_count == 1, "R1 count restarts", match_count, 1);
        check(exp_q.size() == 0, "R2 all expected seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule